// File: doc/BRIEF.md
# PCMCIA Card Memory Window Decoder

This block sits between the memory side of a PCMCIA host slot and a card's local memory bus. The host side is an 8-bit card with a 15-bit address bus. The local bus has one chip enable for Flash and one for SRAM. The block looks at each host memory cycle and decides which kind of cycle it is.

Attribute cycles carry the card information structure. Even attribute bytes below 0800h are folded into the top kilobyte of Flash, and these are read-only. Two card configuration registers are held inside the block and can be written from attribute space. Common cycles pass into a 32K window that is always open. A three-bit bank value, supplied by a neighbouring register block, chooses the device and the two upper local address bits.

From the host output-enable and write-enable strobes, the block produces local read and write strobes. It also produces a single enable that tells the I/O-port logic whether it may answer host I/O cycles.

Top module: `pcm_win_dec`

## Requirements
- R1: After reset both configuration registers read back 00h and `io_resp_en` is low.
- R2: A common cycle (`hst_ce_n`=0, `hst_reg_n`=1) is always claimed. `loc_addr` = {`bank_sel[1:0]`, `hst_addr`}. `bank_sel[2]`=0 selects `loc_flash_ce`, and `bank_sel[2]`=1 selects `loc_sram_ce`. Exactly one of the two is high.
- R3: In a common cycle, `loc_wr` follows `hst_we_n` low. `loc_rd` follows `hst_oe_n` low only while `hst_we_n` is high, so the two strobes are never high together. A read returns `loc_rdata` on `hst_rdata`.
- R4: An attribute read at an even address below 0800h asserts `loc_flash_ce` and `loc_rd`. It drives `loc_addr` = 1FC00h + `hst_addr[10:1]`, ignores `bank_sel`, and returns `loc_rdata`.
- R5: An attribute write below 0800h asserts no chip enable and no `loc_wr`.
- R6: An attribute access at an odd address below 0800h asserts no local enable and reads 00h.
- R7: In attribute space, the option register at 0800h and the status register at 0802h are readable and writable. Each host write-enable assertion stores the data present in its first clock, and only that data.
- R8: A common access to any address, including 0800h and 0802h, never alters the configuration registers.
- R9: `io_resp_en` is high exactly when bits [5:0] of the option register are non-zero. Bits [7:6] alone leave it low.
- R10: Attribute addresses of 0800h and above, other than 0800h and 0802h, are unclaimed: no local enable, no strobe, and a read returns 00h.
- R11: With `hst_ce_n` high, all local enables and strobes are low and `hst_rdata` is 00h.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| hst_ce_n | input | 1 | Host card enable, active low |
| hst_reg_n | input | 1 | Low for attribute space, high for common space |
| hst_oe_n | input | 1 | Host output enable, active low |
| hst_we_n | input | 1 | Host write enable, active low |
| hst_addr | input | 15 | Host byte address |
| hst_wdata | input | 8 | Host write data |
| hst_rdata | output | 8 | Read data to host |
| bank_sel | input | 3 | [2] device select, [1:0] upper local address bits |
| loc_addr | output | 17 | Local memory address |
| loc_wdata | output | 8 | Local write data |
| loc_rdata | input | 8 | Local read data |
| loc_flash_ce | output | 1 | Flash chip enable, active high |
| loc_sram_ce | output | 1 | SRAM chip enable, active high |
| loc_rd | output | 1 | Local read strobe |
| loc_wr | output | 1 | Local write strobe |
| io_resp_en | output | 1 | Permits the I/O-port path to answer host I/O cycles |

## Verification
The hardest case to reach is a write-enable pulse that lasts several clocks while the data changes partway through. Only the first clock of the assertion may be stored. The stimulus holds `hst_we_n` low across two clocks with different data in each, then reads the register back through attribute space. Common writes aimed at 0800h and 0802h are checked the same way: the only place their effect could show is the attribute readback of the registers and `io_resp_en`.

// File: rtl/pcm_win_pkg.sv
package pcm_win_pkg;
    localparam int unsigned PCM_DATA_W = 8;

    typedef struct packed {
        logic [PCM_DATA_W-1:0] opt;
        logic [PCM_DATA_W-1:0] stat;
        logic                  wr_act;
    } cfg_state_t;
endpackage

// File: rtl/pcm_attr_dec.sv
module pcm_attr_dec #(
    parameter int unsigned HOST_AW   = 15,
    parameter int unsigned LOC_AW    = 17,
    parameter int unsigned CIS_AW    = 10,
    parameter logic [14:0] OPT_ADDR  = 15'h0800,
    parameter logic [14:0] STAT_ADDR = 15'h0802
) (
    input  logic [HOST_AW-1:0] addr,
    output logic               cis_hit,
    output logic               sel_opt,
    output logic               sel_stat,
    output logic [LOC_AW-1:0]  cis_addr
);
    localparam int unsigned TOP_W = HOST_AW - CIS_AW - 1;
    localparam int unsigned PAD_W = LOC_AW - CIS_AW;

    logic in_range;

    always_comb begin
        in_range = (addr[HOST_AW-1 -: TOP_W] == '0);
        cis_hit  = in_range && !addr[0];
        sel_opt  = (addr == HOST_AW'(OPT_ADDR));
        sel_stat = (addr == HOST_AW'(STAT_ADDR));
        cis_addr = {{PAD_W{1'b1}}, addr[CIS_AW:1]};
    end
endmodule

// File: rtl/pcm_common_dec.sv
module pcm_common_dec #(
    parameter int unsigned HOST_AW = 15,
    parameter int unsigned BANK_W  = 2,
    parameter int unsigned LOC_AW  = HOST_AW + BANK_W
) (
    input  logic [HOST_AW-1:0] addr,
    input  logic [BANK_W:0]    bank_sel,
    output logic [LOC_AW-1:0]  com_addr,
    output logic               use_sram
);
    always_comb begin
        com_addr = {bank_sel[BANK_W-1:0], addr};
        use_sram = bank_sel[BANK_W];
    end
endmodule

// File: rtl/pcm_cfg_regs.sv
module pcm_cfg_regs
    import pcm_win_pkg::*;
#(
    parameter int unsigned IDX_W = 6
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_act,
    input  logic                  attr_cyc,
    input  logic                  sel_opt,
    input  logic                  sel_stat,
    input  logic [PCM_DATA_W-1:0] wdata,
    output logic [PCM_DATA_W-1:0] opt,
    output logic [PCM_DATA_W-1:0] stat,
    output logic                  io_en
);
    cfg_state_t st_d, st_q;
    logic       wr_first;

    always_comb begin
        st_d        = st_q;
        wr_first    = wr_act && !st_q.wr_act;
        st_d.wr_act = wr_act;
        if (wr_first && attr_cyc && sel_opt)  st_d.opt  = wdata;
        if (wr_first && attr_cyc && sel_stat) st_d.stat = wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign opt   = st_q.opt;
    assign stat  = st_q.stat;
    assign io_en = (st_q.opt[IDX_W-1:0] != '0);
endmodule

// File: rtl/pcm_win_dec.sv
module pcm_win_dec
    import pcm_win_pkg::*;
#(
    parameter int unsigned HOST_AW = 15,
    parameter int unsigned BANK_W  = 2,
    parameter int unsigned CIS_AW  = 10,
    parameter int unsigned IDX_W   = 6,
    localparam int unsigned LOC_AW = HOST_AW + BANK_W
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  hst_ce_n,
    input  logic                  hst_reg_n,
    input  logic                  hst_oe_n,
    input  logic                  hst_we_n,
    input  logic [HOST_AW-1:0]    hst_addr,
    input  logic [PCM_DATA_W-1:0] hst_wdata,
    output logic [PCM_DATA_W-1:0] hst_rdata,
    input  logic [BANK_W:0]       bank_sel,
    output logic [LOC_AW-1:0]     loc_addr,
    output logic [PCM_DATA_W-1:0] loc_wdata,
    input  logic [PCM_DATA_W-1:0] loc_rdata,
    output logic                  loc_flash_ce,
    output logic                  loc_sram_ce,
    output logic                  loc_rd,
    output logic                  loc_wr,
    output logic                  io_resp_en
);
    logic                  cis_hit, sel_opt, sel_stat, use_sram;
    logic [LOC_AW-1:0]     cis_addr, com_addr;
    logic [PCM_DATA_W-1:0] opt, stat;
    logic                  active, attr_cyc, com_cyc, rd_req, wr_req;

    always_comb begin
        active   = !hst_ce_n;
        attr_cyc = active && !hst_reg_n;
        com_cyc  = active && hst_reg_n;
        wr_req   = active && !hst_we_n;
        rd_req   = active && !hst_oe_n && hst_we_n;
    end

    pcm_attr_dec #(
        .HOST_AW (HOST_AW),
        .LOC_AW  (LOC_AW),
        .CIS_AW  (CIS_AW)
    ) attr_i (
        .addr     (hst_addr),
        .cis_hit  (cis_hit),
        .sel_opt  (sel_opt),
        .sel_stat (sel_stat),
        .cis_addr (cis_addr)
    );

    pcm_common_dec #(
        .HOST_AW (HOST_AW),
        .BANK_W  (BANK_W),
        .LOC_AW  (LOC_AW)
    ) com_i (
        .addr     (hst_addr),
        .bank_sel (bank_sel),
        .com_addr (com_addr),
        .use_sram (use_sram)
    );

    pcm_cfg_regs #(
        .IDX_W (IDX_W)
    ) cfg_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_act   (wr_req),
        .attr_cyc (attr_cyc),
        .sel_opt  (sel_opt),
        .sel_stat (sel_stat),
        .wdata    (hst_wdata),
        .opt      (opt),
        .stat     (stat),
        .io_en    (io_resp_en)
    );

    always_comb begin
        loc_addr     = com_cyc ? com_addr : cis_addr;
        loc_wdata    = hst_wdata;
        loc_flash_ce = 1'b0;
        loc_sram_ce  = 1'b0;
        loc_rd       = 1'b0;
        loc_wr       = 1'b0;
        hst_rdata    = '0;
        if (com_cyc) begin
            loc_flash_ce = !use_sram;
            loc_sram_ce  = use_sram;
            loc_rd       = rd_req;
            loc_wr       = wr_req;
            if (rd_req) hst_rdata = loc_rdata;
        end else if (attr_cyc) begin
            if (cis_hit && rd_req) begin
                loc_flash_ce = 1'b1;
                loc_rd       = 1'b1;
                hst_rdata    = loc_rdata;
            end else if (sel_opt && rd_req) begin
                hst_rdata = opt;
            end else if (sel_stat && rd_req) begin
                hst_rdata = stat;
            end
        end
    end
endmodule

// File: rtl/pcm_win_dec_chk.sv
module pcm_win_dec_chk (
    input logic clk,
    input logic rst_n,
    input logic hst_ce_n,
    input logic hst_reg_n,
    input logic hst_addr0,
    input logic loc_flash_ce,
    input logic loc_sram_ce,
    input logic loc_rd,
    input logic loc_wr,
    input logic io_resp_en
);
    assert_io_off_after_reset_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) |-> !io_resp_en);

    assert_one_device_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!hst_ce_n && hst_reg_n) |-> (loc_flash_ce ^ loc_sram_ce));

    assert_strobes_exclusive_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !(loc_rd && loc_wr));

    assert_attr_no_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!hst_ce_n && !hst_reg_n) |-> (!loc_wr && !loc_sram_ce));

    assert_odd_attr_silent_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!hst_ce_n && !hst_reg_n && hst_addr0) |-> !loc_flash_ce);

    assert_common_keeps_cfg_R8: assert property (@(posedge clk) disable iff (!rst_n)
        hst_reg_n |=> $stable(io_resp_en));

    assert_idle_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
        hst_ce_n |-> !(loc_flash_ce || loc_sram_ce || loc_rd || loc_wr));
endmodule

bind pcm_win_dec pcm_win_dec_chk chk_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .hst_ce_n     (hst_ce_n),
    .hst_reg_n    (hst_reg_n),
    .hst_addr0    (hst_addr[0]),
    .loc_flash_ce (loc_flash_ce),
    .loc_sram_ce  (loc_sram_ce),
    .loc_rd       (loc_rd),
    .loc_wr       (loc_wr),
    .io_resp_en   (io_resp_en)
);

// File: tb/pcm_win_dec_tb.sv
module pcm_win_dec_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        hst_ce_n = 1'b1, hst_reg_n = 1'b1, hst_oe_n = 1'b1, hst_we_n = 1'b1;
    logic [14:0] hst_addr = '0;
    logic [7:0]  hst_wdata = '0, loc_rdata = 8'hA5;
    logic [2:0]  bank_sel = '0;
    logic [7:0]  hst_rdata, loc_wdata;
    logic [16:0] loc_addr;
    logic        loc_flash_ce, loc_sram_ce, loc_rd, loc_wr, io_resp_en;
    int          n_run = 0, n_fail = 0;

    always #4 clk = ~clk;

    pcm_win_dec dut_i (
        .clk(clk), .rst_n(rst_n), .hst_ce_n(hst_ce_n), .hst_reg_n(hst_reg_n),
        .hst_oe_n(hst_oe_n), .hst_we_n(hst_we_n), .hst_addr(hst_addr),
        .hst_wdata(hst_wdata), .hst_rdata(hst_rdata), .bank_sel(bank_sel),
        .loc_addr(loc_addr), .loc_wdata(loc_wdata), .loc_rdata(loc_rdata),
        .loc_flash_ce(loc_flash_ce), .loc_sram_ce(loc_sram_ce),
        .loc_rd(loc_rd), .loc_wr(loc_wr), .io_resp_en(io_resp_en)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic idle();
        @(negedge clk);
        hst_ce_n = 1'b1; hst_oe_n = 1'b1; hst_we_n = 1'b1; hst_reg_n = 1'b1;
    endtask

    task automatic attr_write(input logic [14:0] a, input logic [7:0] d);
        @(negedge clk);
        hst_ce_n = 1'b0; hst_reg_n = 1'b0; hst_addr = a; hst_wdata = d; hst_we_n = 1'b0;
        idle();
    endtask

    task automatic attr_read(input logic [14:0] a, output logic [7:0] d);
        @(negedge clk);
        hst_ce_n = 1'b0; hst_reg_n = 1'b0; hst_addr = a; hst_oe_n = 1'b0;
        #1 d = hst_rdata;
        idle();
    endtask

    task automatic t_reset();
        logic [7:0] d;
        check("R1 io_resp_en", 32'(io_resp_en), 0);
        attr_read(15'h0800, d); check("R1 option reg", 32'(d), 0);
        attr_read(15'h0802, d); check("R1 status reg", 32'(d), 0);
    endtask

    task automatic t_common(input logic [14:0] a, input logic [2:0] b);
        @(negedge clk);
        hst_ce_n = 1'b0; hst_reg_n = 1'b1; hst_addr = a; bank_sel = b; hst_oe_n = 1'b0;
        loc_rdata = {a[3:0], b, 1'b1};
        #1;
        check("R2 loc_addr", 32'(loc_addr), 32'({b[1:0], a}));
        check("R2 flash ce", 32'(loc_flash_ce), 32'(!b[2]));
        check("R2 sram ce", 32'(loc_sram_ce), 32'(b[2]));
        check("R3 read strobe", 32'({loc_rd, loc_wr}), 32'b10);
        check("R3 read data", 32'(hst_rdata), 32'({a[3:0], b, 1'b1}));
        @(negedge clk);
        hst_oe_n = 1'b1; hst_we_n = 1'b0; hst_wdata = 8'h3C;
        #1;
        check("R3 write strobe", 32'({loc_rd, loc_wr}), 32'b01);
        check("R3 write data", 32'(loc_wdata), 32'h3C);
        hst_oe_n = 1'b0;
        #1 check("R3 oe+we", 32'({loc_rd, loc_wr}), 32'b01);
        idle();
    endtask

    task automatic t_cis_read(input logic [14:0] a);
        @(negedge clk);
        hst_ce_n = 1'b0; hst_reg_n = 1'b0; hst_addr = a; bank_sel = 3'b111; hst_oe_n = 1'b0;
        loc_rdata = 8'h5A;
        #1;
        check("R4 cis addr", 32'(loc_addr), 32'h1FC00 + 32'(a >> 1));
        check("R4 enables", 32'({loc_flash_ce, loc_sram_ce, loc_rd}), 32'b101);
        check("R4 data", 32'(hst_rdata), 32'h5A);
        idle();
    endtask

    task automatic t_cis_write();
        @(negedge clk);
        hst_ce_n = 1'b0; hst_reg_n = 1'b0; hst_addr = 15'h0010; hst_we_n = 1'b0;
        #1 check("R5 attr write blocked", 32'({loc_flash_ce, loc_sram_ce, loc_wr}), 0);
        idle();
    endtask

    task automatic t_odd();
        @(negedge clk);
        hst_ce_n = 1'b0; hst_reg_n = 1'b0; hst_addr = 15'h0123; hst_oe_n = 1'b0;
        loc_rdata = 8'hEE;
        #1;
        check("R6 odd enables", 32'({loc_flash_ce, loc_rd}), 0);
        check("R6 odd data", 32'(hst_rdata), 0);
        idle();
    endtask

    task automatic t_cfg();
        logic [7:0] d;
        attr_write(15'h0800, 8'h41); attr_read(15'h0800, d);
        check("R7 option rw", 32'(d), 32'h41);
        attr_write(15'h0802, 8'h9C); attr_read(15'h0802, d);
        check("R7 status rw", 32'(d), 32'h9C);
        // long write pulse: only the first clock's data is kept (R7)
        @(negedge clk);
        hst_ce_n = 1'b0; hst_reg_n = 1'b0; hst_addr = 15'h0802; hst_wdata = 8'h11; hst_we_n = 1'b0;
        @(negedge clk); hst_wdata = 8'h22;
        @(negedge clk); idle();
        attr_read(15'h0802, d);
        check("R7 first clock only", 32'(d), 32'h11);
    endtask

    task automatic t_common_no_cfg();
        logic [7:0] d;
        @(negedge clk);
        hst_ce_n = 1'b0; hst_reg_n = 1'b1; hst_addr = 15'h0800; hst_wdata = 8'h00; hst_we_n = 1'b0;
        @(negedge clk); hst_addr = 15'h0802; hst_we_n = 1'b1;
        @(negedge clk); hst_we_n = 1'b0; hst_wdata = 8'hFF;
        idle();
        attr_read(15'h0800, d); check("R8 option kept", 32'(d), 32'h41);
        attr_read(15'h0802, d); check("R8 status kept", 32'(d), 32'h11);
        check("R8 io kept", 32'(io_resp_en), 1);
    endtask

    task automatic t_io_en();
        attr_write(15'h0800, 8'hC0);
        #1 check("R9 upper bits only", 32'(io_resp_en), 0);
        attr_write(15'h0800, 8'h01);
        #1 check("R9 index 1", 32'(io_resp_en), 1);
        attr_write(15'h0800, 8'h20);
        #1 check("R9 index 20h", 32'(io_resp_en), 1);
        attr_write(15'h0800, 8'h00);
        #1 check("R9 cleared", 32'(io_resp_en), 0);
    endtask

    task automatic t_unclaimed();
        logic [7:0] d;
        foreach (d[i]) begin end
        for (int i = 0; i < 3; i++) begin
            logic [14:0] a;
            a = (i == 0) ? 15'h0801 : (i == 1) ? 15'h0804 : 15'h7FFE;
            @(negedge clk);
            hst_ce_n = 1'b0; hst_reg_n = 1'b0; hst_addr = a; hst_oe_n = 1'b0;
            #1;
            check("R10 unclaimed enables", 32'({loc_flash_ce, loc_sram_ce, loc_rd, loc_wr}), 0);
            check("R10 unclaimed data", 32'(hst_rdata), 0);
            idle();
        end
        attr_write(15'h0804, 8'h77);
        attr_read(15'h0800, d); check("R10 no alias write", 32'(d), 0);
    endtask

    task automatic t_idle();
        @(negedge clk);
        hst_ce_n = 1'b1; hst_reg_n = 1'b1; hst_oe_n = 1'b0; hst_we_n = 1'b1; loc_rdata = 8'hFF;
        #1;
        check("R11 idle enables", 32'({loc_flash_ce, loc_sram_ce, loc_rd, loc_wr}), 0);
        check("R11 idle data", 32'(hst_rdata), 0);
        idle();
    endtask

    initial begin
        #2_000_000;
        n_run++; n_fail++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_common(15'h1234, 3'b000);
        t_common(15'h7FFF, 3'b111);
        t_common(15'h0800, 3'b110);
        t_common(15'h4002, 3'b001);
        t_cis_read(15'h0000);
        t_cis_read(15'h07FE);
        t_cis_read(15'h0356);
        t_cis_write();
        t_odd();
        t_cfg();
        t_common_no_cfg();
        t_io_en();
        t_unclaimed();
        t_idle();
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule